// File: doc/BRIEF.md
# Per-Warp Prefetched Register Cache

This block is a small register cache placed between an operand collector and a large, slow main register file. Each active warp slot owns a fixed partition of 16 cache entries. A warp's partition is filled only by an explicit prefetch command. The command names the register working set for the warp's next code interval, and the partition holds those registers until the next command for the same slot arrives. There is no demand fetch and no replacement policy. An operand access that does not find its register in the partition returns an error flag at once and never waits.

When a prefetch command arrives, the block handles the partition in two phases:

- It first walks the 16 entries of the partition. An entry is dropped when it is not part of the new set, or when the slot is being handed to a different warp. A dropped entry that is dirty is written back to the main file under the warp that owned it.
- It then walks the new list. A register that is already resident under the same owner stays where it is. Every other register is given the lowest free entry, and one fill request is sent to the main file for it.

Requests leave the block at most one per cycle. Each request carries a tag made of the active slot and the entry index, so the main file may take any fixed number of cycles to answer. When the last fill for the command has returned, the block raises a one-cycle done pulse on that slot's bit. Only one prefetch is processed at a time. While it runs, operand accesses to the affected slot are refused, and accesses to the other slots proceed normally.

Top module: `warp_regcache`

## Requirements
- R1: After reset the block shows pf_ready high, pf_done all zero, no main-file request, and neither acc_rvalid nor acc_miss.
- R2: After a prefetch for slot w with owner g completes, a read of any listed register returns that register's value from the main file for warp g. The result appears with acc_rvalid one cycle after the request, and acc_miss stays low.
- R3: An operand write that hits updates the entry and marks it dirty, and later reads return the written value. No main-file write occurs at the time of the operand write.
- R4: When a new prefetch keeps the same owner, any listed register that is already resident keeps its slot and its current (possibly dirty) value and gets no fill request. Fill requests are issued only for listed registers that are not resident. The listed registers are distinct and there are at most 16 of them (pf_count from 0 to 16; pf_regs entry i sits in bits 6i+5 down to 6i).
- R5: During a prefetch, every dirty entry that is not in the new set is written back once, with mrf_req_we high, carrying its owner, its register ID and its value. Clean entries are never written back.
- R6: A prefetch that names a different owner than the slot's current one writes back all dirty entries under the old owner, keeps no entry, and fetches every listed register for the new owner.
- R7: An access to a register that is not resident in the slot's partition, or to a slot that has never been prefetched, gives acc_miss high and acc_rvalid low one cycle later, and changes no state.
- R8: Fill and writeback requests go out at most one per cycle. The bit pf_done[w] pulses high for exactly one cycle after the last fill of slot w has returned, and pf_ready is high in that cycle. A list with pf_count 0 finishes after its writebacks and needs no fill.
- R9: While a prefetch for slot w is in progress, any access to slot w gives acc_miss.
- R10: A prefetch on one slot leaves the contents of the other slots unchanged, and those slots remain accessible while it runs.
- R11: Correct operation does not depend on the main-file latency. Each response is matched by its slot and entry tag, and it is accepted only while a fill is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch command valid, taken when pf_ready is high |
| pf_warp | input | WI_W (1) | Active slot the command targets |
| pf_gwarp | input | GWARP_W (4) | Warp that owns the slot from this interval on |
| pf_regs | input | 96 | Register list, entry i in bits 6i+5:6i |
| pf_count | input | 5 | Number of valid list entries (0 to 16) |
| pf_ready | output | 1 | No prefetch in progress |
| pf_done | output | NUM_WARPS (2) | One-cycle completion pulse per slot |
| acc_valid | input | 1 | Operand access valid |
| acc_warp | input | WI_W (1) | Slot of the access |
| acc_reg | input | 6 | Architectural register ID |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_rvalid | output | 1 | Read hit result valid |
| acc_rdata | output | 32 | Read data |
| acc_miss | output | 1 | Access did not hit (error flag) |
| mrf_req_valid | output | 1 | Main-file request valid |
| mrf_req_we | output | 1 | 1 = writeback, 0 = fill read |
| mrf_req_gwarp | output | GWARP_W (4) | Warp addressed in the main file |
| mrf_req_reg | output | 6 | Register addressed in the main file |
| mrf_req_wdata | output | 32 | Writeback data |
| mrf_req_warp | output | WI_W (1) | Slot tag returned with the fill |
| mrf_req_slot | output | 4 | Entry tag returned with the fill |
| mrf_rsp_valid | input | 1 | Fill response valid |
| mrf_rsp_warp | input | WI_W (1) | Slot tag of the response |
| mrf_rsp_slot | input | 4 | Entry tag of the response |
| mrf_rsp_data | input | 32 | Fill data |

## Verification
The cache keeps several kinds of internal state. A wrong tag, a lost dirty bit or a misplaced fill shows up at the ports in one of three ways: a read returning a value different from the architectural value one cycle after the request, a hit reported as a miss, or a different number of fill or writeback requests during the next prefetch. A missing writeback shows up only later, when another slot fetches the same warp's registers and reads a stale value. For that reason the bench moves owners between slots and ends by flushing every partition and comparing the whole main file.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
  localparam int RC_SLOTS  = 16;
  localparam int RC_RID_W  = 6;
  localparam int RC_DATA_W = 32;
  localparam int RC_SLOT_W = $clog2(RC_SLOTS);
  localparam int RC_CNT_W  = RC_SLOT_W + 1;

  typedef logic [RC_RID_W-1:0]  rid_t;
  typedef logic [RC_SLOT_W-1:0] slot_t;
  typedef logic [RC_CNT_W-1:0]  cnt_t;
  typedef logic [RC_DATA_W-1:0] word_t;
  typedef rid_t [RC_SLOTS-1:0]  rlist_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_EVICT, SQ_FILL, SQ_WAIT} sq_state_t;

  // true when key is among the first n entries of lst
  function automatic logic rc_in_list(rlist_t lst, cnt_t n, rid_t key);
    logic found;
    found = 1'b0;
    for (int i = 0; i < RC_SLOTS; i++)
      if (i < int'(n) && lst[i] == key) found = 1'b1;
    return found;
  endfunction

  // true when a valid entry carries key as its tag
  function automatic logic rc_holds(rlist_t tags, logic [RC_SLOTS-1:0] vmask, rid_t key);
    logic found;
    found = 1'b0;
    for (int i = 0; i < RC_SLOTS; i++)
      if (vmask[i] && tags[i] == key) found = 1'b1;
    return found;
  endfunction

  // lowest entry not in use
  function automatic slot_t rc_first_free(logic [RC_SLOTS-1:0] used);
    slot_t s;
    s = '0;
    for (int i = RC_SLOTS-1; i >= 0; i--)
      if (!used[i]) s = slot_t'(i);
    return s;
  endfunction
endpackage

// File: rtl/rc_tag_match.sv
`timescale 1ns/1ps
module rc_tag_match
  import rc_pkg::*;
(
  input  rlist_t               tags,
  input  logic [RC_SLOTS-1:0]  vmask,
  input  rid_t                 key,
  output logic                 hit,
  output slot_t                idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < RC_SLOTS; i++) begin
      if (vmask[i] && tags[i] == key) begin
        hit = 1'b1;
        idx = slot_t'(i);
      end
    end
  end
endmodule

// File: rtl/rc_partition.sv
`timescale 1ns/1ps
module rc_partition
  import rc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  slot_t                wr_slot,
  input  word_t                wr_data,
  input  logic                 fill_en,
  input  slot_t                fill_slot,
  input  word_t                fill_data,
  input  logic                 inv_en,
  input  slot_t                inv_slot,
  input  logic                 alloc_en,
  input  slot_t                alloc_slot,
  input  rid_t                 alloc_tag,
  output logic [RC_SLOTS-1:0]  valid,
  output logic [RC_SLOTS-1:0]  pending,
  output logic [RC_SLOTS-1:0]  dirty,
  output rlist_t               tags,
  output word_t [RC_SLOTS-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= '0;
      pending <= '0;
      dirty   <= '0;
      tags    <= '0;
    end else begin
      if (inv_en) begin
        valid[inv_slot]   <= 1'b0;
        pending[inv_slot] <= 1'b0;
        dirty[inv_slot]   <= 1'b0;
      end
      if (alloc_en) begin
        valid[alloc_slot]   <= 1'b1;
        pending[alloc_slot] <= 1'b1;
        dirty[alloc_slot]   <= 1'b0;
        tags[alloc_slot]    <= alloc_tag;
      end
      if (wr_en)   dirty[wr_slot]     <= 1'b1;
      if (fill_en) pending[fill_slot] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)   data[wr_slot]   <= wr_data;
    if (fill_en) data[fill_slot] <= fill_data;
  end
endmodule

// File: rtl/rc_prefetch_seq.sv
`timescale 1ns/1ps
module rc_prefetch_seq
  import rc_pkg::*;
#(
  parameter int NUM_WARPS = 2,
  parameter int GWARP_W   = 4,
  localparam int WI_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pf_valid,
  input  logic [WI_W-1:0]      pf_warp,
  input  logic [GWARP_W-1:0]   pf_gwarp,
  input  rlist_t               pf_list,
  input  cnt_t                 pf_count,
  input  logic [RC_SLOTS-1:0]  s_valid,
  input  logic [RC_SLOTS-1:0]  s_dirty,
  input  rlist_t               s_tags,
  input  word_t [RC_SLOTS-1:0] s_data,
  input  logic                 rsp_valid,
  output logic                 pf_ready,
  output logic                 seq_busy,
  output logic                 seq_evicting,
  output logic [WI_W-1:0]      seq_warp,
  output logic                 inv_en,
  output slot_t                inv_slot,
  output logic                 alloc_en,
  output slot_t                alloc_slot,
  output rid_t                 alloc_tag,
  output logic                 req_valid,
  output logic                 req_we,
  output logic [GWARP_W-1:0]   req_gwarp,
  output rid_t                 req_reg,
  output word_t                req_wdata,
  output slot_t                req_slot,
  output logic [NUM_WARPS-1:0] done,
  output cnt_t                 fill_cnt
);
  sq_state_t            state;
  cnt_t                 idx;
  logic [GWARP_W-1:0]   new_g;
  rlist_t               list;
  cnt_t                 count;
  logic                 repurpose;
  logic [GWARP_W-1:0]   owner [NUM_WARPS];
  logic [NUM_WARPS-1:0] owner_v;

  slot_t walk_slot;
  logic  drop, resident, fill_issue;
  rid_t  fill_key;
  slot_t free_slot;

  assign pf_ready     = (state == SQ_IDLE);
  assign seq_busy     = (state != SQ_IDLE);
  assign seq_evicting = (state == SQ_EVICT);
  assign walk_slot    = idx[RC_SLOT_W-1:0];
  assign fill_key     = list[walk_slot];
  assign drop         = s_valid[walk_slot] &&
                        (repurpose || !rc_in_list(list, count, s_tags[walk_slot]));
  assign resident     = rc_holds(s_tags, s_valid, fill_key);
  assign free_slot    = rc_first_free(s_valid);
  assign fill_issue   = (state == SQ_FILL) && !resident;

  always_comb begin
    inv_en     = 1'b0;
    inv_slot   = walk_slot;
    alloc_en   = 1'b0;
    alloc_slot = free_slot;
    alloc_tag  = fill_key;
    req_valid  = 1'b0;
    req_we     = 1'b0;
    req_gwarp  = new_g;
    req_reg    = fill_key;
    req_wdata  = s_data[walk_slot];
    req_slot   = free_slot;
    if (state == SQ_EVICT) begin
      inv_en    = drop;
      req_valid = drop && s_dirty[walk_slot];
      req_we    = 1'b1;
      req_gwarp = owner[seq_warp];
      req_reg   = s_tags[walk_slot];
      req_slot  = walk_slot;
    end else if (state == SQ_FILL) begin
      alloc_en  = !resident;
      req_valid = !resident;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      idx       <= '0;
      seq_warp  <= '0;
      new_g     <= '0;
      list      <= '0;
      count     <= '0;
      repurpose <= 1'b0;
      done      <= '0;
      fill_cnt  <= '0;
      owner_v   <= '0;
      for (int w = 0; w < NUM_WARPS; w++) owner[w] <= '0;
    end else begin
      done <= '0;
      if (fill_issue && !rsp_valid)      fill_cnt <= fill_cnt + 1'b1;
      else if (!fill_issue && rsp_valid) fill_cnt <= fill_cnt - 1'b1;
      case (state)
        SQ_IDLE: if (pf_valid) begin
          seq_warp  <= pf_warp;
          new_g     <= pf_gwarp;
          list      <= pf_list;
          count     <= pf_count;
          repurpose <= !owner_v[pf_warp] || (owner[pf_warp] != pf_gwarp);
          idx       <= '0;
          state     <= SQ_EVICT;
        end
        SQ_EVICT: begin
          if (idx == cnt_t'(RC_SLOTS-1)) begin
            idx               <= '0;
            owner[seq_warp]   <= new_g;
            owner_v[seq_warp] <= 1'b1;
            state             <= (count == '0) ? SQ_WAIT : SQ_FILL;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SQ_FILL: begin
          if (idx == count - 1'b1) state <= SQ_WAIT;
          else                     idx   <= idx + 1'b1;
        end
        SQ_WAIT: if (fill_cnt == '0) begin
          done[seq_warp] <= 1'b1;
          state          <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/warp_regcache.sv
`timescale 1ns/1ps
module warp_regcache
  import rc_pkg::*;
#(
  parameter int NUM_WARPS = 2,
  parameter int GWARP_W   = 4,
  localparam int WI_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pf_valid,
  input  logic [WI_W-1:0]              pf_warp,
  input  logic [GWARP_W-1:0]           pf_gwarp,
  input  logic [RC_SLOTS*RC_RID_W-1:0] pf_regs,
  input  logic [RC_CNT_W-1:0]          pf_count,
  output logic                         pf_ready,
  output logic [NUM_WARPS-1:0]         pf_done,
  input  logic                         acc_valid,
  input  logic [WI_W-1:0]              acc_warp,
  input  logic [RC_RID_W-1:0]          acc_reg,
  input  logic                         acc_we,
  input  logic [RC_DATA_W-1:0]         acc_wdata,
  output logic                         acc_rvalid,
  output logic [RC_DATA_W-1:0]         acc_rdata,
  output logic                         acc_miss,
  output logic                         mrf_req_valid,
  output logic                         mrf_req_we,
  output logic [GWARP_W-1:0]           mrf_req_gwarp,
  output logic [RC_RID_W-1:0]          mrf_req_reg,
  output logic [RC_DATA_W-1:0]         mrf_req_wdata,
  output logic [WI_W-1:0]              mrf_req_warp,
  output logic [RC_SLOT_W-1:0]         mrf_req_slot,
  input  logic                         mrf_rsp_valid,
  input  logic [WI_W-1:0]              mrf_rsp_warp,
  input  logic [RC_SLOT_W-1:0]         mrf_rsp_slot,
  input  logic [RC_DATA_W-1:0]         mrf_rsp_data
);
  logic [RC_SLOTS-1:0]  p_valid   [NUM_WARPS];
  logic [RC_SLOTS-1:0]  p_pending [NUM_WARPS];
  logic [RC_SLOTS-1:0]  p_dirty   [NUM_WARPS];
  rlist_t               p_tags    [NUM_WARPS];
  word_t [RC_SLOTS-1:0] p_data    [NUM_WARPS];

  rlist_t          pf_list;
  logic            seq_busy, seq_evicting;
  logic [WI_W-1:0] seq_warp;
  logic            inv_en, alloc_en;
  slot_t           inv_slot, alloc_slot;
  rid_t            alloc_tag;
  cnt_t            fill_cnt;

  // named events for the checker
  logic  acc_locked, acc_tag_hit, acc_hit;
  slot_t acc_idx;

  assign pf_list = pf_regs;

  rc_tag_match i_acc_match (
    .tags  (p_tags[acc_warp]),
    .vmask (p_valid[acc_warp] & ~p_pending[acc_warp]),
    .key   (acc_reg),
    .hit   (acc_tag_hit),
    .idx   (acc_idx)
  );

  assign acc_locked = seq_busy && (seq_warp == acc_warp);
  assign acc_hit    = acc_valid && acc_tag_hit && !acc_locked;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_part
    logic sel_seq;
    assign sel_seq = (seq_warp == WI_W'(w));
    rc_partition i_part (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (acc_hit && acc_we && (acc_warp == WI_W'(w))),
      .wr_slot    (acc_idx),
      .wr_data    (acc_wdata),
      .fill_en    (mrf_rsp_valid && (mrf_rsp_warp == WI_W'(w))),
      .fill_slot  (mrf_rsp_slot),
      .fill_data  (mrf_rsp_data),
      .inv_en     (inv_en && sel_seq),
      .inv_slot   (inv_slot),
      .alloc_en   (alloc_en && sel_seq),
      .alloc_slot (alloc_slot),
      .alloc_tag  (alloc_tag),
      .valid      (p_valid[w]),
      .pending    (p_pending[w]),
      .dirty      (p_dirty[w]),
      .tags       (p_tags[w]),
      .data       (p_data[w])
    );
  end

  rc_prefetch_seq #(.NUM_WARPS(NUM_WARPS), .GWARP_W(GWARP_W)) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pf_valid     (pf_valid),
    .pf_warp      (pf_warp),
    .pf_gwarp     (pf_gwarp),
    .pf_list      (pf_list),
    .pf_count     (pf_count),
    .s_valid      (p_valid[seq_warp]),
    .s_dirty      (p_dirty[seq_warp]),
    .s_tags       (p_tags[seq_warp]),
    .s_data       (p_data[seq_warp]),
    .rsp_valid    (mrf_rsp_valid),
    .pf_ready     (pf_ready),
    .seq_busy     (seq_busy),
    .seq_evicting (seq_evicting),
    .seq_warp     (seq_warp),
    .inv_en       (inv_en),
    .inv_slot     (inv_slot),
    .alloc_en     (alloc_en),
    .alloc_slot   (alloc_slot),
    .alloc_tag    (alloc_tag),
    .req_valid    (mrf_req_valid),
    .req_we       (mrf_req_we),
    .req_gwarp    (mrf_req_gwarp),
    .req_reg      (mrf_req_reg),
    .req_wdata    (mrf_req_wdata),
    .req_slot     (mrf_req_slot),
    .done         (pf_done),
    .fill_cnt     (fill_cnt)
  );

  assign mrf_req_warp = seq_warp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rvalid <= 1'b0;
      acc_miss   <= 1'b0;
      acc_rdata  <= '0;
    end else begin
      acc_rvalid <= acc_hit && !acc_we;
      acc_miss   <= acc_valid && !acc_hit;
      acc_rdata  <= p_data[acc_warp][acc_idx];
    end
  end
endmodule

// File: rtl/rc_checker.sv
`timescale 1ns/1ps
module rc_checker
  import rc_pkg::*;
#(
  parameter int NUM_WARPS = 2
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pf_ready,
  input logic [NUM_WARPS-1:0] pf_done,
  input logic                 acc_valid,
  input logic                 acc_locked,
  input logic                 acc_rvalid,
  input logic                 acc_miss,
  input logic                 mrf_req_valid,
  input logic                 mrf_req_we,
  input logic                 mrf_rsp_valid,
  input logic                 seq_evicting,
  input cnt_t                 fill_cnt
);
  assert_done_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pf_done));

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_done != '0) |-> pf_ready);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_done != '0) |=> (pf_done == '0));

  assert_fill_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mrf_req_valid && !mrf_req_we) |-> !pf_ready);

  assert_wb_evict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mrf_req_valid && mrf_req_we) |-> seq_evicting);

  assert_rsp_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mrf_rsp_valid |-> (fill_cnt != '0));

  assert_locked_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_locked) |=> (acc_miss && !acc_rvalid));

  assert_miss_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_miss && acc_rvalid));
endmodule

bind warp_regcache rc_checker #(.NUM_WARPS(NUM_WARPS)) i_rc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .pf_ready      (pf_ready),
  .pf_done       (pf_done),
  .acc_valid     (acc_valid),
  .acc_locked    (acc_locked),
  .acc_rvalid    (acc_rvalid),
  .acc_miss      (acc_miss),
  .mrf_req_valid (mrf_req_valid),
  .mrf_req_we    (mrf_req_we),
  .mrf_rsp_valid (mrf_rsp_valid),
  .seq_evicting  (seq_evicting),
  .fill_cnt      (fill_cnt)
);

// File: tb/test_warp_regcache.sv
`timescale 1ns/1ps
module test_warp_regcache;
  localparam int NW = 2, GW = 4, LAT = 6, NREG = 64, NG = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n;

  logic          pf_valid;
  logic [0:0]    pf_warp;
  logic [GW-1:0] pf_gwarp;
  logic [95:0]   pf_regs;
  logic [4:0]    pf_count;
  logic          pf_ready;
  logic [NW-1:0] pf_done;
  logic          acc_valid, acc_we;
  logic [0:0]    acc_warp;
  logic [5:0]    acc_reg;
  logic [31:0]   acc_wdata, acc_rdata;
  logic          acc_rvalid, acc_miss;
  logic          mrf_req_valid, mrf_req_we;
  logic [GW-1:0] mrf_req_gwarp;
  logic [5:0]    mrf_req_reg;
  logic [31:0]   mrf_req_wdata;
  logic [0:0]    mrf_req_warp;
  logic [3:0]    mrf_req_slot;
  logic          mrf_rsp_valid;
  logic [0:0]    mrf_rsp_warp;
  logic [3:0]    mrf_rsp_slot;
  logic [31:0]   mrf_rsp_data;

  warp_regcache #(.NUM_WARPS(NW), .GWARP_W(GW)) i_warp_regcache (.*);

  int checks = 0, failures = 0;
  logic [31:0] mrf  [NG][NREG];
  logic [31:0] arch [NG][NREG];
  bit res [NW][NREG];
  bit dty [NW][NREG];
  int own [NW];
  bit owned [NW];
  int fills_seen = 0, wbs_seen = 0;
  int exp_fill, exp_wb, snap_fill, snap_wb;
  logic [31:0] seed = 32'h1234_5678;

  logic        pv [LAT];
  logic [0:0]  pw [LAT];
  logic [3:0]  ps [LAT];
  logic [31:0] pd [LAT];

  function automatic logic [31:0] init_word(int g, int r);
    return 32'hC0DE_0000 | (g << 8) | r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_rand(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  // main register file: fixed-latency delay line, tags echoed back
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) pv[k] = 1'b0;
      mrf_rsp_valid = 1'b0;
    end else begin
      mrf_rsp_valid = pv[LAT-1];
      mrf_rsp_warp  = pw[LAT-1];
      mrf_rsp_slot  = ps[LAT-1];
      mrf_rsp_data  = pd[LAT-1];
      for (int k = LAT-1; k > 0; k--) begin
        pv[k] = pv[k-1]; pw[k] = pw[k-1]; ps[k] = ps[k-1]; pd[k] = pd[k-1];
      end
      pv[0] = mrf_req_valid && !mrf_req_we;
      pw[0] = mrf_req_warp;
      ps[0] = mrf_req_slot;
      pd[0] = mrf[mrf_req_gwarp][mrf_req_reg];
      if (mrf_req_valid && mrf_req_we) begin
        mrf[mrf_req_gwarp][mrf_req_reg] = mrf_req_wdata;
        wbs_seen++;
      end
      if (mrf_req_valid && !mrf_req_we) fills_seen++;
    end
  end

  // issue a prefetch of list (st + i*sd) mod 64, i < n, and predict its traffic
  task automatic pf_start(input int w, input int g, input int n, input int st, input int sd);
    bit inl [NREG];
    bit rep;
    for (int r = 0; r < NREG; r++) inl[r] = 0;
    pf_regs = '0;
    for (int i = 0; i < n; i++) begin
      int r = (st + i * sd) % NREG;
      inl[r] = 1;
      pf_regs[i*6 +: 6] = 6'(r);
    end
    rep = !owned[w] || own[w] != g;
    exp_fill = 0; exp_wb = 0;
    for (int r = 0; r < NREG; r++) begin
      if (res[w][r] && dty[w][r] && (rep || !inl[r])) exp_wb++;
      if (inl[r] && !(res[w][r] && !rep)) exp_fill++;
    end
    for (int r = 0; r < NREG; r++) begin
      if (!inl[r] || rep) dty[w][r] = 0;
      res[w][r] = inl[r];
    end
    own[w] = g; owned[w] = 1;
    snap_fill = fills_seen; snap_wb = wbs_seen;
    pf_valid = 1'b1; pf_warp = 1'(w); pf_gwarp = GW'(g); pf_count = 5'(n);
    @(negedge clk);
    pf_valid = 1'b0;
  endtask

  task automatic pf_wait(input int w, input string tag_fill, input string tag_wb);
    int cnt = 0;
    while (!pf_done[w] && cnt < 500) begin
      @(negedge clk);
      cnt++;
    end
    check(pf_done == NW'(1 << w), "R8 done pulse on own bit", 64'(pf_done), 64'(1 << w));
    check(pf_ready == 1'b1, "R8 ready with done", 64'(pf_ready), 64'd1);
    check(fills_seen - snap_fill == exp_fill, tag_fill, 64'(fills_seen - snap_fill), 64'(exp_fill));
    check(wbs_seen - snap_wb == exp_wb, tag_wb, 64'(wbs_seen - snap_wb), 64'(exp_wb));
    @(negedge clk);
    check(pf_done == '0, "R8 done lasts one cycle", 64'(pf_done), 64'd0);
  endtask

  task automatic access(input int w, input int r, input bit we, input logic [31:0] d,
                        input bit locked, input string tag);
    bit exp_hit = owned[w] && res[w][r] && !locked;
    acc_valid = 1'b1; acc_warp = 1'(w); acc_reg = 6'(r); acc_we = we; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    check(acc_miss == !exp_hit, tag, 64'(acc_miss), 64'(!exp_hit));
    check(acc_rvalid == (exp_hit && !we), tag, 64'(acc_rvalid), 64'(exp_hit && !we));
    if (exp_hit && !we)
      check(acc_rdata == arch[own[w]][r], tag, 64'(acc_rdata), 64'(arch[own[w]][r]));
    if (exp_hit && we) begin
      arch[own[w]][r] = d;
      dty[w][r] = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rv, rv2;
    int snap;
    for (int g = 0; g < NG; g++)
      for (int r = 0; r < NREG; r++) begin
        mrf[g][r] = init_word(g, r);
        arch[g][r] = init_word(g, r);
      end
    for (int w = 0; w < NW; w++) begin
      owned[w] = 0; own[w] = 0;
      for (int r = 0; r < NREG; r++) begin res[w][r] = 0; dty[w][r] = 0; end
    end
    rst_n = 1'b0; pf_valid = 0; pf_warp = 0; pf_gwarp = 0; pf_regs = '0; pf_count = 0;
    acc_valid = 0; acc_warp = 0; acc_reg = 0; acc_we = 0; acc_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pf_ready == 1'b1, "R1 ready after reset", 64'(pf_ready), 64'd1);
    check(pf_done == '0, "R1 no done after reset", 64'(pf_done), 64'd0);
    check(mrf_req_valid == 1'b0, "R1 no request after reset", 64'(mrf_req_valid), 64'd0);
    check(!acc_rvalid && !acc_miss, "R1 access outputs idle", 64'({acc_rvalid, acc_miss}), 64'd0);

    // full working set, then read every entry
    pf_start(0, 2, 16, 0, 1);
    pf_wait(0, "R2 fill count full set", "R2 no writeback on first fill");
    for (int r = 0; r < 16; r++) access(0, r, 0, '0, 0, "R2 read after prefetch");

    // writes hit, no main-file traffic
    snap = wbs_seen;
    access(0, 3, 1, 32'hAAAA_0003, 0, "R3 write hit");
    access(0, 7, 1, 32'hAAAA_0007, 0, "R3 write hit");
    access(0, 15, 1, 32'hAAAA_000F, 0, "R3 write hit");
    check(wbs_seen == snap, "R3 no write-through", 64'(wbs_seen - snap), 64'd0);
    access(0, 3, 0, '0, 0, "R3 read back");
    access(0, 15, 0, '0, 0, "R3 read back");

    // misses
    access(0, 40, 0, '0, 0, "R7 miss on absent register");
    access(1, 0, 0, '0, 0, "R7 miss on empty slot");
    access(0, 41, 1, 32'hDEAD, 0, "R7 write miss");
    access(0, 7, 0, '0, 0, "R7 state unchanged after miss");

    // prefetch on slot 1 while slot 0 stays usable
    pf_start(1, 5, 4, 10, 3);
    access(1, 10, 0, '0, 1, "R9 access during own prefetch");
    access(0, 3, 0, '0, 0, "R10 other slot served during prefetch");
    pf_wait(1, "R11 fills returned at latency 6", "R10 no writeback");
    for (int i = 0; i < 4; i++) access(1, 10 + 3 * i, 0, '0, 0, "R10 slot 1 contents");
    access(0, 7, 0, '0, 0, "R10 slot 0 untouched");

    // same owner: 7,11,15 kept (7,15 dirty), 19,23 new, dirty 3 written back
    pf_start(0, 2, 5, 7, 4);
    pf_wait(0, "R4 only absent registers fetched", "R5 dirty outside new set written back");
    access(0, 7, 0, '0, 0, "R4 retained dirty value");
    access(0, 15, 0, '0, 0, "R4 retained dirty value");
    access(0, 19, 0, '0, 0, "R4 new register");
    access(0, 3, 0, '0, 0, "R5 dropped register misses");

    // new owner: everything dirty goes back, nothing kept
    pf_start(0, 6, 3, 7, 1);
    pf_wait(0, "R6 all fetched for new owner", "R6 all dirty written back");
    for (int r = 7; r < 10; r++) access(0, r, 0, '0, 0, "R6 new owner values");

    // the old owner's registers come back with written values via the main file
    pf_start(1, 2, 16, 0, 1);
    pf_wait(1, "R6 refetch count", "R6 clean slot no writeback");
    for (int r = 0; r < 16; r++) access(1, r, 0, '0, 0, "R5 written-back values refetched");

    // sweep: slot 1 uses odd owners, slot 0 even owners
    for (int round = 0; round < 30; round++) begin
      int w = (round + 1) % 2;
      int g, n, st, sd;
      next_rand(rv);
      g = 2 * int'(rv[2:0]) + w;
      n = int'(rv[8:4]) % 17;
      st = int'(rv[15:10]);
      sd = 2 * int'(rv[20:16]) + 1;
      if (rv[24]) g = own[w] | (g & 0);
      pf_start(w, g, n, st, sd);
      pf_wait(w, "R4 sweep fill count", "R5 sweep writeback count");
      for (int k = 0; k < 6 && n > 0; k++) begin
        next_rand(rv2);
        access(w, (st + (int'(rv2[7:0]) % n) * sd) % NREG, 1, rv2, 0, "R3 sweep write");
      end
      for (int r = 0; r < NREG; r++) access(w, r, 0, '0, 0, "R2 sweep read");
      for (int r = 0; r < NREG; r += 9) access(1 - w, r, 0, '0, 0, "R10 sweep other slot");
    end

    // empty lists flush both partitions
    pf_start(0, own[0], 0, 0, 1);
    pf_wait(0, "R8 empty list needs no fill", "R5 flush writebacks");
    pf_start(1, own[1], 0, 0, 1);
    pf_wait(1, "R8 empty list needs no fill", "R5 flush writebacks");
    begin
      int bad = 0;
      for (int g = 0; g < NG; g++)
        for (int r = 0; r < NREG; r++)
          if (mrf[g][r] !== arch[g][r]) bad++;
      check(bad == 0, "R5 main file matches architectural state", 64'(bad), 64'd0);
    end
    access(0, 7, 0, '0, 0, "R7 miss after flush");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule